// File: doc/BRIEF.md
# Push-Button Debounce Filter

This block cleans up one mechanical push-button that pulls its line low while pressed and floats high when released. The raw line is first brought into the clock domain by a short flop chain. A four-state machine then decides what the key is doing: at rest, qualifying a press, held, or qualifying a release. A change of level is believed only after the synchronized line has stayed at the new value long enough, and any contradicting sample sends the machine back to the stable state it came from.

Two outputs come out. One is a filtered level that follows the key's polarity: 1 released, 0 pressed. The other is a single-cycle strobe that fires once for each confirmed press. A key bank instantiates one copy per button. The qualification length is a parameter. On silicon it is set for roughly 20 ms of system clock, which is a million cycles at 50 MHz. In simulation it can be cut to a handful of cycles.

Top module: `btn_settle`

## Requirements
- R1: While `rst_n` is low, and after its release until a press is accepted, `key_level` is 1 and `key_press` is 0. Reset acts asynchronously: it takes effect with no clock edge.
- R2: Let `key_raw_n` go to 0 after steady 1 and stay there. `key_level` drops to 0 on the (HOLD_CYCLES + SYNC_STAGES + 1)-th rising edge after the change, and not before.
- R3: `key_press` is 1 for exactly one clock cycle, and only in the cycle in which `key_level` has just gone from 1 to 0.
- R4: A low run of `key_raw_n` lasting HOLD_CYCLES cycles or fewer leaves `key_level` at 1 and produces no strobe. A low run of HOLD_CYCLES + 1 cycles is accepted as a press.
- R5: When a pressed key returns to 1 and stays there, `key_level` rises to 1 with the same latency as in R2, and no strobe is produced on release.
- R6: While the key is accepted as pressed, a high run of HOLD_CYCLES cycles or fewer leaves `key_level` at 0 and produces no strobe.
- R7: A key held low for any length of time produces exactly one strobe.
- R8: A bouncing press, made of short low and high runs that end in a steady low, produces exactly one strobe. A bouncing release produces none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_raw_n | input | 1 | Raw button line, 0 while pressed |
| key_level | output | 1 | Filtered key level, 1 released, 0 pressed |
| key_press | output | 1 | One-cycle strobe on each accepted press |

## Verification
The bench builds the block with HOLD_CYCLES = 5 and SYNC_STAGES = 2. With those values every qualification window is a few cycles long, so the exact acceptance edge can be checked. Low and high runs of one to five cycles, which must be rejected, can be compared against a run of six cycles, which must be accepted, on both the press side and the release side. Bounce trains can mix all of these widths in a few hundred cycles, and holds many times longer than the window confirm that only one strobe is produced.

// File: rtl/btn_settle_pkg.sv
package btn_settle_pkg;

   typedef enum logic [1:0] {
      BS_REST         = 2'd0,
      BS_PRESS_QUAL   = 2'd1,
      BS_HELD         = 2'd2,
      BS_RELEASE_QUAL = 2'd3
   } btn_state_e;

   localparam logic KEY_RELEASED = 1'b1;

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   import btn_settle_pkg::*;

   logic [STAGES-1:0] pipe_q;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe_q[0] <= KEY_RELEASED;
               else        pipe_q[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe_q[g] <= KEY_RELEASED;
               else        pipe_q[g] <= pipe_q[g-1];
            end
         end
      end
   endgenerate

   assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/btn_hold_timer.sv
module btn_hold_timer #(
   parameter int HOLD_CYCLES = 1_000_000,
   parameter int CNT_W       = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   output logic             done,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;

   assign done  = (cnt_q == LAST);
   assign count = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (run && !done)    cnt_q <= cnt_q + 1'b1;
      else                      cnt_q <= '0;
   end

endmodule

// File: rtl/btn_settle.sv
module btn_settle #(
   parameter int HOLD_CYCLES = 1_000_000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic key_raw_n,
   output logic key_level,
   output logic key_press
);
   import btn_settle_pkg::*;

   localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;

   generate
      if (HOLD_CYCLES < 1) begin : g_bad_hold
         $error("btn_settle: HOLD_CYCLES must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("btn_settle: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             key_sync;
   logic             hold_run;
   logic             hold_done;
   logic [CNT_W-1:0] hold_cnt;
   btn_state_e       state_q;
   logic             level_q;
   logic             press_q;

   btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (key_raw_n),
      .dout (key_sync)
   );

   assign hold_run = ((state_q == BS_PRESS_QUAL)   && !key_sync) ||
                     ((state_q == BS_RELEASE_QUAL) &&  key_sync);

   btn_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES), .CNT_W(CNT_W)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (hold_run),
      .done (hold_done),
      .count(hold_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= BS_REST;
         level_q <= KEY_RELEASED;
         press_q <= 1'b0;
      end else begin
         press_q <= 1'b0;
         unique case (state_q)
            BS_REST: begin
               if (!key_sync) state_q <= BS_PRESS_QUAL;
            end
            BS_PRESS_QUAL: begin
               if (key_sync) begin
                  state_q <= BS_REST;
               end else if (hold_done) begin
                  state_q <= BS_HELD;
                  level_q <= ~KEY_RELEASED;
                  press_q <= 1'b1;
               end
            end
            BS_HELD: begin
               if (key_sync) state_q <= BS_RELEASE_QUAL;
            end
            BS_RELEASE_QUAL: begin
               if (!key_sync) begin
                  state_q <= BS_HELD;
               end else if (hold_done) begin
                  state_q <= BS_REST;
                  level_q <= KEY_RELEASED;
               end
            end
            default: state_q <= BS_REST;
         endcase
      end
   end

   assign key_level = level_q;
   assign key_press = press_q;

endmodule

// File: rtl/btn_settle_chk.sv
module btn_settle_chk #(
   parameter int HOLD_CYCLES = 5,
   parameter int CNT_W       = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             key_level,
   input logic             key_press,
   input logic             key_sync,
   input logic [CNT_W-1:0] hold_cnt
);

   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      key_press |=> !key_press);                                          // R3

   AST_STROBE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      key_press |-> (!key_level && $past(key_level)));                     // R3

   AST_NO_STROBE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(key_level) |-> !key_press);                                   // R5

   AST_FALL_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(key_level) |-> !$past(key_sync));                             // R2

   AST_RISE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(key_level) |-> $past(key_sync));                              // R5

   AST_WINDOW_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      int'(hold_cnt) < HOLD_CYCLES);                                      // R4

endmodule

bind btn_settle btn_settle_chk #(.HOLD_CYCLES(HOLD_CYCLES), .CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .key_level(key_level),
   .key_press(key_press),
   .key_sync (key_sync),
   .hold_cnt (hold_cnt)
);

// File: tb/btn_settle_bench.sv
module btn_settle_bench;

   localparam int HOLD = 5;
   localparam int SYNC = 2;
   localparam int LAT  = HOLD + SYNC + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic key_raw_n = 1'b1;
   logic key_level;
   logic key_press;

   int checks = 0;
   int fails  = 0;
   int press_seen = 0;
   int falls_seen = 0;
   int rises_seen = 0;
   logic prev_level = 1'b1;
   bit done = 1'b0;

   always #5 clk = ~clk;

   btn_settle #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(SYNC)) u_btn_settle (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_raw_n(key_raw_n),
      .key_level(key_level),
      .key_press(key_press)
   );

   always @(negedge clk) begin
      if (key_press) press_seen++;
      if (prev_level && !key_level) falls_seen++;
      if (!prev_level && key_level) rises_seen++;
      prev_level <= key_level;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic v, input int n);
      key_raw_n = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      key_raw_n = 1'b1;
      repeat (3) @(negedge clk);
      check(key_level == 1'b1, "R1", "level in reset", key_level, 1);
      check(key_press == 1'b0, "R1", "strobe in reset", key_press, 0);
      rst_n = 1'b1;
      drive(1'b1, 2 * LAT);
      check(key_level == 1'b1, "R1", "level after reset", key_level, 1);
      check(press_seen == 0, "R1", "strobes after reset", press_seen, 0);
   endtask

   task automatic t_press_hold_release;
      int p0 = press_seen;
      drive(1'b0, LAT - 1);
      check(key_level == 1'b1, "R2", "level one edge before accept", key_level, 1);
      drive(1'b0, 1);
      check(key_level == 1'b0, "R2", "level at accept edge", key_level, 0);
      check(key_press == 1'b1, "R3", "strobe at accept edge", key_press, 1);
      drive(1'b0, 1);
      check(key_press == 1'b0, "R3", "strobe one cycle later", key_press, 0);
      drive(1'b0, 60);
      check(press_seen - p0 == 1, "R7", "strobes over long hold", press_seen - p0, 1);
      drive(1'b1, LAT - 1);
      check(key_level == 1'b0, "R5", "level one edge before release", key_level, 0);
      drive(1'b1, 1);
      check(key_level == 1'b1, "R5", "level at release edge", key_level, 1);
      drive(1'b1, 2 * LAT);
      check(press_seen - p0 == 1, "R5", "strobes after release", press_seen - p0, 1);
   endtask

   task automatic t_press_glitch;
      int p0 = press_seen;
      int f0 = falls_seen;
      for (int w = 1; w <= HOLD; w++) begin
         drive(1'b0, w);
         drive(1'b1, 2 * LAT);
      end
      check(falls_seen == f0, "R4", "level falls from short lows", falls_seen - f0, 0);
      check(press_seen == p0, "R4", "strobes from short lows", press_seen - p0, 0);
      check(key_level == 1'b1, "R4", "level after short lows", key_level, 1);
   endtask

   task automatic t_boundary;
      int p0 = press_seen;
      drive(1'b0, HOLD + 1);
      drive(1'b1, LAT);
      check(press_seen - p0 == 1, "R4", "strobe from low run of HOLD+1", press_seen - p0, 1);
      drive(1'b1, 2 * LAT);
      check(key_level == 1'b1, "R5", "level back after boundary press", key_level, 1);
   endtask

   task automatic t_release_glitch;
      int p0;
      int r0;
      drive(1'b0, 2 * LAT);
      p0 = press_seen;
      r0 = rises_seen;
      for (int w = 1; w <= HOLD; w++) begin
         drive(1'b1, w);
         drive(1'b0, 2 * LAT);
      end
      check(rises_seen == r0, "R6", "level rises from short highs", rises_seen - r0, 0);
      check(press_seen == p0, "R6", "strobes from short highs", press_seen - p0, 0);
      check(key_level == 1'b0, "R6", "level after short highs", key_level, 0);
      drive(1'b1, 2 * LAT);
      check(key_level == 1'b1, "R5", "level after steady release", key_level, 1);
   endtask

   task automatic t_bouncy;
      int p0 = press_seen;
      drive(1'b0, 2); drive(1'b1, 1); drive(1'b0, 3); drive(1'b1, 2);
      drive(1'b0, 1); drive(1'b1, 3); drive(1'b0, 4); drive(1'b1, 1);
      drive(1'b0, 40);
      check(press_seen - p0 == 1, "R8", "strobes on bouncy press", press_seen - p0, 1);
      check(key_level == 1'b0, "R8", "level after bouncy press", key_level, 0);
      p0 = press_seen;
      drive(1'b1, 2); drive(1'b0, 1); drive(1'b1, 3); drive(1'b0, 2);
      drive(1'b1, 5); drive(1'b0, 1);
      drive(1'b1, 40);
      check(press_seen == p0, "R8", "strobes on bouncy release", press_seen - p0, 0);
      check(key_level == 1'b1, "R8", "level after bouncy release", key_level, 1);
   endtask

   task automatic t_async_reset;
      drive(1'b0, 2 * LAT);
      check(key_level == 1'b0, "R1", "pressed before reset", key_level, 0);
      #2 rst_n = 1'b0;
      #1;
      check(key_level == 1'b1, "R1", "level right after async reset", key_level, 1);
      @(negedge clk);
      key_raw_n = 1'b1;
      drive(1'b1, 2);
      rst_n = 1'b1;
      drive(1'b1, 2 * LAT);
      check(key_level == 1'b1, "R1", "level after reset release", key_level, 1);
   endtask

   task automatic summary;
      $display("  %0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_press_hold_release();
      t_press_glitch();
      t_boundary();
      t_release_glitch();
      t_bouncy();
      t_async_reset();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         summary();
         $finish;
      end
   end

endmodule